// File: doc/BRIEF.md
# Select-Accumulate Datapath Machine

A narrow datapath built from a 2-way multiplexer, a ripple adder and a state register. On every rising clock edge the register captures operand `op_a` plus a second value. The `pick_b` line chooses that second value: operand `op_b`, or the register's own current contents. Choosing `op_b` loads a fresh `a+b`. Choosing feedback adds `a` once more onto the running total. A short sequence of select values can therefore build expressions such as `3a+b`.

The select line works like a two-state operation code. The value named LOAD (`pick_b` = 1) takes the OPERAND source. The value named ACCUMULATE (`pick_b` = 0) takes the FEEDBACK source. The machine keeps no other state, so it may change between the two on any cycle. Synchronous reset forces the register to zero from either operation. All arithmetic wraps at 16, and the carry out of the top stage is dropped.

Top module: `sel_accum_machine`

## Requirements
- R1: Operands, mux output, adder output, register and `result` are all WIDTH bits wide, with WIDTH = 4 by default.
- R2: While `rst` is 1 at a rising edge, the register becomes 0000, whatever the values of `pick_b`, `op_a` and `op_b`. After reset is released, the first observed result is 0.
- R3: When `pick_b` = 1 (LOAD) at a rising edge and `rst` = 0, the next `result` equals (`op_a` + `op_b`) mod 16.
- R4: When `pick_b` = 0 (ACCUMULATE) at a rising edge and `rst` = 0, the next `result` equals (`op_a` + previous `result`) mod 16.
- R5: `result` is the register contents. It changes only at a rising clock edge and does not follow operand or select changes between edges.
- R6: Sums above 15 wrap modulo 16, the carry-in is 0 and the carry-out is discarded; for example 15+15 gives 14 and 15+1 gives 0.
- R7: With `op_a` = 3 and `op_b` = 4, one LOAD followed by two ACCUMULATE cycles gives the result sequence 0, 7, 10, 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 4 | Addend applied on every cycle |
| op_b | input | 4 | Operand taken when `pick_b` = 1 |
| pick_b | input | 1 | 1 = LOAD (take `op_b`), 0 = ACCUMULATE (take feedback) |
| result | output | 4 | Current register contents |

## Verification
The assertions check on every cycle the following behaviours:
- Reset clears the register.
- Each LOAD or ACCUMULATE edge produces the wrapped sum of the values sampled at that edge.
- The ripple adder agrees with modulo-16 addition.

The bench scenarios are needed for the rest:
- The concrete 0, 7, 10, 13 sequence.
- The exact wrap points at 14 and 0.
- The fact that `result` stays still while operands and select toggle between edges.
- A long mixed run compared against an independent model.

// File: rtl/sam_pkg.sv
package sam_pkg;
    typedef enum logic {
        SRC_FEEDBACK = 1'b0,
        SRC_OPERAND  = 1'b1
    } src_e;
endpackage

// File: rtl/sam_src_mux.sv
module sam_src_mux
    import sam_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  src_e             sel,
    input  logic [WIDTH-1:0] operand,
    input  logic [WIDTH-1:0] feedback,
    output logic [WIDTH-1:0] chosen
);
    always_comb begin
        unique case (sel)
            SRC_OPERAND:  chosen = operand;
            SRC_FEEDBACK: chosen = feedback;
            default:      chosen = feedback;
        endcase
    end
endmodule

// File: rtl/sam_ripple_adder.sv
module sam_ripple_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        assign sum[i] = x[i] ^ y[i] ^ carry[i];
        if (i < WIDTH - 1) begin : g_carry
            assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
        end
    end

    // R6: the bit-level chain must agree with arithmetic modulo 2**WIDTH
    always_comb begin
        if (!$isunknown({x, y})) begin
            p_sum_wraps_r6: assert (sum == WIDTH'(x + y))
                else $error("ripple sum mismatch");
        end
    end
endmodule

// File: rtl/sam_state_reg.sv
module sam_state_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R2: a reset edge leaves the register at zero
    p_reset_clears_r2: assert property (@(posedge clk) rst |=> (q == '0))
        else $error("register not cleared by reset");

    // R5: outside reset the register takes exactly what was presented at the edge
    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q == $past(d)))
        else $error("register did not capture d");
endmodule

// File: rtl/sel_accum_machine.sv
module sel_accum_machine
    import sam_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             pick_b,
    output logic [WIDTH-1:0] result
);
    src_e             src;
    logic [WIDTH-1:0] chosen;
    logic [WIDTH-1:0] next_sum;
    logic [WIDTH-1:0] acc_q;

    assign src = src_e'(pick_b);

    sam_src_mux #(.WIDTH(WIDTH)) u_mux (
        .sel      (src),
        .operand  (op_b),
        .feedback (acc_q),
        .chosen   (chosen)
    );

    sam_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x   (op_a),
        .y   (chosen),
        .sum (next_sum)
    );

    sam_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (next_sum),
        .q   (acc_q)
    );

    assign result = acc_q;

    // R3: LOAD edge yields a+b wrapped
    p_load_sum_r3: assert property (@(posedge clk) disable iff (rst)
        pick_b |=> (result == WIDTH'($past(op_a) + $past(op_b))))
        else $error("load step wrong");

    // R4: ACCUMULATE edge adds a onto the previous result
    p_accum_step_r4: assert property (@(posedge clk) disable iff (rst)
        !pick_b |=> (result == WIDTH'($past(op_a) + $past(result))))
        else $error("accumulate step wrong");
endmodule

// File: tb/test_sel_accum_machine.sv
module test_sel_accum_machine;
    localparam int PERIOD = 10;
    localparam int NVEC   = 10;
    // each entry: {a, b, pick_b, expected result after the edge}
    localparam logic [12:0] TBL [NVEC] = '{
        {4'd3,  4'd4, 1'b1, 4'd7},   // R7 load
        {4'd3,  4'd0, 1'b0, 4'd10},  // R7 accumulate
        {4'd3,  4'd9, 1'b0, 4'd13},  // R7 accumulate, b ignored
        {4'd5,  4'd1, 1'b0, 4'd2},   // R6 wrap 18
        {4'd15, 4'd15,1'b1, 4'd14},  // R6 wrap 30
        {4'd15, 4'd2, 1'b0, 4'd13},  // R4 wrap 29
        {4'd0,  4'd9, 1'b1, 4'd9},   // R3
        {4'd0,  4'd3, 1'b0, 4'd9},   // R4 hold via a=0
        {4'd1,  4'd0, 1'b1, 4'd1},   // R3
        {4'd15, 4'd7, 1'b0, 4'd0}    // R6 exact 16
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic       pick_b = 1'b0;
    logic [3:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sel_accum_machine i_sel_accum_machine (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .pick_b(pick_b), .result(result)
    );

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: result=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: result=%0d expected=done", result);
        finish_run();
    end

    initial begin
        logic [3:0] model;
        // R2: reset with active-looking inputs still gives zero
        op_a = 4'd9; op_b = 4'd6; pick_b = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 reset state", result, 4'd0);
        rst = 1'b0; op_a = 4'd0; op_b = 4'd0; pick_b = 1'b0;
        @(negedge clk);
        check("R7 first result zero", result, 4'd0);

        // table walk: drive at negedge, check at following negedge
        for (int i = 0; i < NVEC; i++) begin
            op_a   = TBL[i][12:9];
            op_b   = TBL[i][8:5];
            pick_b = TBL[i][4];
            @(negedge clk);
            check($sformatf("R3/R4/R6/R7 vector %0d", i), result, TBL[i][3:0]);
        end

        // R5: toggle inputs between edges; output must not move
        model = result;
        for (int k = 0; k < 4; k++) begin
            op_a = 4'(k * 5 + 1); op_b = 4'(k + 7); pick_b = k[0];
            #1;
            check("R5 stable between edges", result, model);
        end
        op_a = 4'd2; pick_b = 1'b0;
        @(negedge clk);
        check("R5 updates at edge", result, 4'(model + 4'd2));

        // R2: reset mid-accumulation, with LOAD selected
        op_a = 4'd7; op_b = 4'd7; pick_b = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R2 reset during run", result, 4'd0);
        rst = 1'b0; pick_b = 1'b0; op_a = 4'd4;
        @(negedge clk);
        check("R4 accumulate after reset", result, 4'd4);

        // long mixed run against an independent model (R3 R4 R6 R1)
        model = 4'd4;
        for (int j = 0; j < 40; j++) begin
            op_a   = 4'((j * 7 + 3) % 16);
            op_b   = 4'((j * 11 + 5) % 16);
            pick_b = ((j % 5) == 0);
            model  = 4'((op_a + (pick_b ? op_b : model)) % 16);
            @(negedge clk);
            check($sformatf("R1/R3/R4/R6 model step %0d", j), result, model);
        end

        finish_run();
    end
endmodule